// File: doc/BRIEF.md
# Configuration Page Write Guard

This block owns the identifier page and the configuration page of a small transponder memory that is organised in pages of four bytes, with four pages to a block. It holds both pages in registers and loads them at reset from parameters that stand in for non-volatile contents. Every page write that reaches it is checked against the access rules. A write is then either committed or refused as a whole, and a one-cycle status pulse reports which.

Downstream logic reads the configuration as decoded fields: the memory size code, the authentication mode, the settings for tag-initiated transmission, the master lock and the eight page-range lock fuses. The block also gives two permission flags for the key and password area. A single master lock bit changes the write rules at run time. Once set, it freezes the control byte and turns the lock-fuse byte into set-only bits.

Top module: `cfg_page_guard`

## Requirements
- R1: After reset, page 0 reads `UID_INIT`, page 1 reads `CFG_INIT`, and neither status pulse is asserted.
- R2: Every write to page 0 is refused, and the identifier never changes.
- R3: Page 1 bits [1:0] hold the size code (00 means 32 bits, 01 means 256 bits, 10 means 2048 bits) and are read-only. A write whose bits [1:0] differ from the stored value is refused. `mem_size_o` shows the stored code.
- R4: Page 1 layout: [31:24] reserved, [23:16] lock fuses, [15:8] control byte, [7:0] size byte. The control byte from bit 7 down to bit 0 holds auth mode, encoding, rate[1:0], transmit pages[1:0], master lock and key lock. The decoded outputs follow the stored word in the cycle after an accepted write. The reserved byte and bits [7:2] are freely writable.
- R5: While the master lock (bit 9) is 0, the control byte and the lock-fuse byte take the written value as-is, including clearing bits.
- R6: Once the master lock reads 1, it never returns to 0. A write that would clear it is refused.
- R7: While the master lock is 1, a write whose control byte differs from the stored one is refused as a whole, and all of page 1 is left unchanged.
- R8: While the master lock is 1, each lock fuse becomes the OR of its old value and the written bit. Written zeros have no effect, and such a write is accepted.
- R9: `key_wr_ok_o` is the inverse of key lock. `key_rd_ok_o` is 0 only when key lock and auth mode are both 1.
- R10: A write to page 0 or page 1 raises exactly one of `wr_ack_o` and `wr_nack_o`, for one cycle, in the cycle after the write edge. A write to any other page raises neither and changes nothing.
- R11: `rd_data_o` follows `rd_page_i` without a clock: page 0 gives the identifier, page 1 gives the configuration, and any other page gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_page_i | input | PAGE_AW | Write page address |
| wr_data_i | input | 32 | Write data |
| rd_page_i | input | PAGE_AW | Read page address |
| rd_data_o | output | 32 | Read data |
| wr_ack_o | output | 1 | Write committed pulse |
| wr_nack_o | output | 1 | Write refused pulse |
| mem_size_o | output | 2 | Memory size code |
| auth_mode_o | output | 1 | Authentication mode |
| ttf_enc_o | output | 1 | Tag-initiated encoding select |
| ttf_rate_o | output | 2 | Tag-initiated data rate |
| ttf_pages_o | output | 2 | Tag-initiated page range (00 = off) |
| cfg_locked_o | output | 1 | Master lock |
| key_lock_o | output | 1 | Key area lock |
| page_lock_o | output | 8 | Page-range lock fuses |
| key_wr_ok_o | output | 1 | Key area writable |
| key_rd_ok_o | output | 1 | Key area readable |

## Verification
The bench first sets the master lock. It then tries to clear it, to change the control byte, and to write zeros into set fuses. A design that treats the lock as an ordinary bit would let the lock return to 0. A design that merges the control byte would not refuse it. A design that overwrites fuses would lose lock bits that were already set. The bench also checks that a refused write leaves the other bytes untouched even when they changed too, that writes to a foreign page stay silent, and both key-permission combinations. Without these checks, a partial commit or a swapped permission term would go unnoticed.

// File: rtl/cfg_guard_pkg.sv
`timescale 1ns/1ps
package cfg_guard_pkg;
  localparam int unsigned PAGE_BYTES = 4;
  localparam int unsigned PAGE_W     = 8 * PAGE_BYTES;
  localparam int unsigned LCK_W      = 8;

  typedef struct packed {
    logic [7:0]       rsv;
    logic [LCK_W-1:0] lck;
    logic [7:0]       ctl;
    logic [7:0]       size;
  } cfg_word_t;

  // control byte bit positions
  localparam int unsigned CTL_AUTH = 7;
  localparam int unsigned CTL_ENC  = 6;
  localparam int unsigned CTL_RATE = 4;
  localparam int unsigned CTL_TTF  = 2;
  localparam int unsigned CTL_MLCK = 1;
  localparam int unsigned CTL_KLCK = 0;
endpackage

// File: rtl/cfg_wr_rules.sv
`timescale 1ns/1ps
module cfg_wr_rules
  import cfg_guard_pkg::*;
(
  input  cfg_word_t cur_i,
  input  cfg_word_t wdata_i,
  input  logic      sel_uid_i,
  input  logic      sel_cfg_i,
  output logic      accept_o,
  output logic      reject_o,
  output cfg_word_t next_o
);
  logic mlck;
  logic ro_hit;

  assign mlck   = cur_i.ctl[CTL_MLCK];
  assign ro_hit = (wdata_i.size[1:0] != cur_i.size[1:0]) |
                  (mlck & (wdata_i.ctl != cur_i.ctl));

  assign accept_o = sel_cfg_i & ~ro_hit;
  assign reject_o = sel_uid_i | (sel_cfg_i & ro_hit);

  assign next_o.rsv  = wdata_i.rsv;
  assign next_o.size = {wdata_i.size[7:2], cur_i.size[1:0]};
  assign next_o.ctl  = mlck ? cur_i.ctl : wdata_i.ctl;

  // fuse merge per lock bit
  for (genvar i = 0; i < LCK_W; i++) begin : g_fuse
    assign next_o.lck[i] = mlck ? (cur_i.lck[i] | wdata_i.lck[i]) : wdata_i.lck[i];
  end
endmodule

// File: rtl/cfg_field_decode.sv
`timescale 1ns/1ps
module cfg_field_decode
  import cfg_guard_pkg::*;
(
  input  cfg_word_t        cfg_i,
  output logic [1:0]       mem_size_o,
  output logic             auth_mode_o,
  output logic             ttf_enc_o,
  output logic [1:0]       ttf_rate_o,
  output logic [1:0]       ttf_pages_o,
  output logic             cfg_locked_o,
  output logic             key_lock_o,
  output logic [LCK_W-1:0] page_lock_o,
  output logic             key_wr_ok_o,
  output logic             key_rd_ok_o
);
  assign mem_size_o   = cfg_i.size[1:0];
  assign auth_mode_o  = cfg_i.ctl[CTL_AUTH];
  assign ttf_enc_o    = cfg_i.ctl[CTL_ENC];
  assign ttf_rate_o   = cfg_i.ctl[CTL_RATE +: 2];
  assign ttf_pages_o  = cfg_i.ctl[CTL_TTF +: 2];
  assign cfg_locked_o = cfg_i.ctl[CTL_MLCK];
  assign key_lock_o   = cfg_i.ctl[CTL_KLCK];
  assign page_lock_o  = cfg_i.lck;
  // locked key area: read-only in plain mode, sealed in auth mode
  assign key_wr_ok_o  = ~cfg_i.ctl[CTL_KLCK];
  assign key_rd_ok_o  = ~(cfg_i.ctl[CTL_KLCK] & cfg_i.ctl[CTL_AUTH]);
endmodule

// File: rtl/cfg_page_guard.sv
`timescale 1ns/1ps
module cfg_page_guard
  import cfg_guard_pkg::*;
#(
  parameter int unsigned PAGE_AW  = 6,
  parameter logic [31:0] UID_INIT = 32'hA5C3_1E77,
  parameter logic [31:0] CFG_INIT = 32'h0000_0002
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [PAGE_AW-1:0] wr_page_i,
  input  logic [31:0]        wr_data_i,
  input  logic [PAGE_AW-1:0] rd_page_i,
  output logic [31:0]        rd_data_o,
  output logic               wr_ack_o,
  output logic               wr_nack_o,
  output logic [1:0]         mem_size_o,
  output logic               auth_mode_o,
  output logic               ttf_enc_o,
  output logic [1:0]         ttf_rate_o,
  output logic [1:0]         ttf_pages_o,
  output logic               cfg_locked_o,
  output logic               key_lock_o,
  output logic [7:0]         page_lock_o,
  output logic               key_wr_ok_o,
  output logic               key_rd_ok_o
);
  localparam logic [PAGE_AW-1:0] UID_PG = PAGE_AW'(0);
  localparam logic [PAGE_AW-1:0] CFG_PG = PAGE_AW'(1);

  logic [PAGE_W-1:0] uid_q;
  cfg_word_t         cfg_q, cfg_nxt;
  logic              sel_uid, sel_cfg, accept, reject;
  logic              ack_q, nack_q;

  assign sel_uid = wr_en_i & (wr_page_i == UID_PG);
  assign sel_cfg = wr_en_i & (wr_page_i == CFG_PG);

  cfg_wr_rules u_rules (
    .cur_i    (cfg_q),
    .wdata_i  (cfg_word_t'(wr_data_i)),
    .sel_uid_i(sel_uid),
    .sel_cfg_i(sel_cfg),
    .accept_o (accept),
    .reject_o (reject),
    .next_o   (cfg_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uid_q  <= UID_INIT;
      cfg_q  <= cfg_word_t'(CFG_INIT);
      ack_q  <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      ack_q  <= accept;
      nack_q <= reject;
      if (accept) cfg_q <= cfg_nxt;
    end
  end

  always_comb begin
    unique case (rd_page_i)
      UID_PG:  rd_data_o = uid_q;
      CFG_PG:  rd_data_o = cfg_q;
      default: rd_data_o = '0;
    endcase
  end

  assign wr_ack_o  = ack_q;
  assign wr_nack_o = nack_q;

  cfg_field_decode u_dec (
    .cfg_i       (cfg_q),
    .mem_size_o  (mem_size_o),
    .auth_mode_o (auth_mode_o),
    .ttf_enc_o   (ttf_enc_o),
    .ttf_rate_o  (ttf_rate_o),
    .ttf_pages_o (ttf_pages_o),
    .cfg_locked_o(cfg_locked_o),
    .key_lock_o  (key_lock_o),
    .page_lock_o (page_lock_o),
    .key_wr_ok_o (key_wr_ok_o),
    .key_rd_ok_o (key_rd_ok_o)
  );
endmodule

// File: rtl/cfg_page_guard_chk.sv
`timescale 1ns/1ps
module cfg_page_guard_chk #(
  parameter int unsigned PAGE_AW = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [PAGE_AW-1:0] wr_page_i,
  input logic               wr_ack_o,
  input logic               wr_nack_o,
  input logic [1:0]         mem_size_o,
  input logic               auth_mode_o,
  input logic               ttf_enc_o,
  input logic [1:0]         ttf_rate_o,
  input logic [1:0]         ttf_pages_o,
  input logic               cfg_locked_o,
  input logic               key_lock_o,
  input logic [7:0]         page_lock_o
);
  a_r2_uid_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_page_i == '0) |=> (wr_nack_o && !wr_ack_o));

  a_r3_size_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mem_size_o));

  a_r6_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_locked_o |=> cfg_locked_o);

  a_r7_ctl_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_locked_o |=> $stable({auth_mode_o, ttf_enc_o, ttf_rate_o, ttf_pages_o, key_lock_o}));

  a_r8_fuse_setonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_locked_o |=> (($past(page_lock_o) & ~page_lock_o) == 8'h00));

  a_r10_one_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ack_o && wr_nack_o));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (!wr_ack_o && !wr_nack_o));
endmodule

bind cfg_page_guard cfg_page_guard_chk #(.PAGE_AW(PAGE_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_page_i   (wr_page_i),
  .wr_ack_o    (wr_ack_o),
  .wr_nack_o   (wr_nack_o),
  .mem_size_o  (mem_size_o),
  .auth_mode_o (auth_mode_o),
  .ttf_enc_o   (ttf_enc_o),
  .ttf_rate_o  (ttf_rate_o),
  .ttf_pages_o (ttf_pages_o),
  .cfg_locked_o(cfg_locked_o),
  .key_lock_o  (key_lock_o),
  .page_lock_o (page_lock_o)
);

// File: tb/tb_cfg_page_guard.sv
`timescale 1ns/1ps
module tb_cfg_page_guard;
  localparam int unsigned AW  = 6;
  localparam logic [31:0] UID = 32'hA5C3_1E77;
  localparam logic [31:0] CFG = 32'h0000_0002;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_page = '0, rd_page = '0;
  logic [31:0]   wr_data = '0, rd_data;
  logic          ack, nack, auth, enc, mlck, klck, kwr, krd;
  logic [1:0]    msize, rate, ttf;
  logic [7:0]    lck;

  cfg_page_guard #(.PAGE_AW(AW), .UID_INIT(UID), .CFG_INIT(CFG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_page_i(wr_page),
    .wr_data_i(wr_data), .rd_page_i(rd_page), .rd_data_o(rd_data),
    .wr_ack_o(ack), .wr_nack_o(nack), .mem_size_o(msize), .auth_mode_o(auth),
    .ttf_enc_o(enc), .ttf_rate_o(rate), .ttf_pages_o(ttf), .cfg_locked_o(mlck),
    .key_lock_o(klck), .page_lock_o(lck), .key_wr_ok_o(kwr), .key_rd_ok_o(krd)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          stamp;
    string       tag;
    logic        ack;
    logic        nack;
    logic [31:0] cfg;
  } exp_t;

  exp_t        sb[$];
  int          total = 0, bad = 0, cyc = 0;
  logic [31:0] model_cfg = CFG;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference rules taken from the requirements
  task automatic model(input logic [AW-1:0] a, input logic [31:0] d,
                       output logic ok_a, output logic ok_n);
    logic lk;
    ok_a = 1'b0; ok_n = 1'b0;
    lk = model_cfg[9];
    if (a == 0) ok_n = 1'b1;
    else if (a == 1) begin
      if (d[1:0] != model_cfg[1:0] || (lk && d[15:8] != model_cfg[15:8])) ok_n = 1'b1;
      else begin
        ok_a = 1'b1;
        model_cfg = {d[31:24], lk ? (model_cfg[23:16] | d[23:16]) : d[23:16], d[15:8], d[7:0]};
      end
    end
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    logic ea, en;
    model(a, d, ea, en);
    @(negedge clk);
    wr_en = 1'b1; wr_page = a; wr_data = d;
    e.stamp = cyc; e.tag = tag; e.ack = ea; e.nack = en; e.cfg = model_cfg;
    sb.push_back(e);
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  // monitor: checks status, both pages and decoded fields one cycle after each write
  always @(negedge clk) begin
    if (sb.size() != 0 && sb[0].stamp == cyc - 1) begin
      exp_t e;
      logic [31:0] c;
      e = sb.pop_front();
      c = e.cfg;
      chk(ack == e.ack && nack == e.nack, {e.tag, " R10 status"}, {30'd0, ack, nack}, {30'd0, e.ack, e.nack});
      rd_page = AW'(1); #1;
      chk(rd_data == c, {e.tag, " R11 page1"}, rd_data, c);
      rd_page = AW'(0); #1;
      chk(rd_data == UID, "R2 uid kept", rd_data, UID);
      chk({lck, auth, enc, rate, ttf, mlck, klck, 6'd0, msize} == {c[23:8], 6'd0, c[1:0]},
          {e.tag, " R4 decode"}, {8'd0, lck, auth, enc, rate, ttf, mlck, klck, 6'd0, msize},
          {8'd0, c[23:8], 6'd0, c[1:0]});
      chk(kwr == ~c[8] && krd == ~(c[8] & c[15]), {e.tag, " R9 key perms"},
          {30'd0, kwr, krd}, {30'd0, ~c[8], ~(c[8] & c[15])});
    end
  end

  bit done = 1'b0;
  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R10 actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset contents
    chk(ack == 1'b0 && nack == 1'b0, "R1 status idle", {30'd0, ack, nack}, 32'd0);
    rd_page = AW'(1); #1;
    chk(rd_data == CFG, "R1 cfg init", rd_data, CFG);
    rd_page = AW'(0); #1;
    chk(rd_data == UID, "R1 uid init", rd_data, UID);
    rd_page = AW'(2); #1;
    chk(rd_data == 32'd0, "R11 other page zero", rd_data, 32'd0);
    chk(msize == 2'b10, "R3 size 2048 code", {30'd0, msize}, 32'd2);

    drive(AW'(0), 32'h1234_5678, "R2 uid write");
    drive(AW'(1), 32'h0000_0001, "R3 size change");
    drive(AW'(1), 32'h0C5A_D5FE, "R5 free write auth+klck");
    drive(AW'(1), 32'h0000_2102, "R5 clear fuses plain klck");
    drive(AW'(5), 32'hFFFF_FFFF, "R10 foreign page");
    drive(AW'(1), 32'h0011_3202, "R6 set master lock");
    drive(AW'(1), 32'h77FF_3302, "R7 ctl change refused");
    drive(AW'(1), 32'h0000_3202, "R8 zeros keep fuses");
    drive(AW'(1), 32'h0024_3202, "R8 fuse or");
    drive(AW'(1), 32'h0000_3002, "R6 clear lock refused");
    drive(AW'(1), 32'hAB00_32FE, "R4 reserved bits free");
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R10 scoreboard drained", sb.size(), 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule